// File: doc/BRIEF.md
# UART Interrupt Identification Unit

This block works out which interrupt a classic single-buffer UART reports and drives the one interrupt request line. It takes the receiver data-ready flag, the transmitter-holding-empty flag, the break indicator and the interrupt enable bits. It also keeps two hidden flags of its own: a transmit-pending flag and a modem-changed flag. From these it builds an 8-bit identification code through a fixed-priority selector.

Host accesses have side effects on the hidden flags, and the block applies them. Reading the identification code clears the modem-changed flag. The same read clears the transmit-pending flag when the code being read is the transmit code. Writing the enable register sets transmit-pending while the holding register is empty. Writing a transmit byte clears transmit-pending, and the hand-off of that byte sets it again. The code and the request line are registered. A host read returns the value held before that read's own side effects take effect.

Top module: `uart_irq_ident`

## Requirements
- R1: The code follows a fixed priority, highest first: data-ready with enable bit 0 gives 0x04; transmit-pending with enable bit 1 gives 0x02; modem-changed with enable bit 2 gives 0x06; a set break indicator, with no enable, gives 0x00; with none of these the code is 0x01.
- R2: `irq` is high exactly when the code differs from 0x01.
- R3: After reset the code is 0x01, `irq` is low, and both hidden flags are clear.
- R4: A read of the code whose low three bits are 3'b010 clears transmit-pending. A read that returns any other code leaves transmit-pending unchanged.
- R5: Every read of the code clears the modem-changed flag.
- R6: An enable-register write sets transmit-pending when `ln_thr_empty` is high in that cycle. When `ln_thr_empty` is low, the write leaves the flag unchanged.
- R7: A transmit-byte write clears transmit-pending, and a `tx_handoff` pulse sets it.
- R8: A `modem_evt` pulse sets the modem-changed flag.
- R9: The code is registered. A change of an input in cycle N is visible after edge N. A hidden-flag change made at edge N is visible after edge N+1. During a read, `iir_val` shows the code from before that read's side effects.
- R10: When a set event and a clear event hit the same hidden flag in the same cycle, the flag ends up set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ier_en | input | 3 | Interrupt enables: bit 0 receive data, bit 1 transmit, bit 2 modem change |
| ln_data_ready | input | 1 | Receive buffer holds a byte |
| ln_thr_empty | input | 1 | Transmit holding register is empty |
| ln_break | input | 1 | Break indicator |
| modem_evt | input | 1 | One-cycle pulse: modem status inputs were updated |
| host_iir_rd | input | 1 | One-cycle pulse: host reads the identification code |
| host_ier_wr | input | 1 | One-cycle pulse: host writes the enable register |
| host_thr_wr | input | 1 | One-cycle pulse: host writes a transmit byte |
| tx_handoff | input | 1 | One-cycle pulse: the transmit byte has been handed off |
| iir_val | output | 8 | Registered identification code, also the read data |
| irq | output | 1 | Level interrupt request |

## Verification
The bench builds the block with its default 3-bit enable width and the package's four-source code table. With these values every source can be reached, both alone and against each of the others. The table-driven part resets the block before each vector. It then sets up one mix of static line inputs and flag-setting pulses and checks the settled code against the priority list. Directed tests cover the cycle-accurate staleness of the code during and after a read, the conditional clearing of transmit-pending, and same-cycle set/clear collisions on both hidden flags.

// File: rtl/uart_iid_pkg.sv
package uart_iid_pkg;
    localparam int IID_W    = 8;
    localparam int IID_NSRC = 4;

    // Source index order is the priority order (index 0 highest)
    localparam logic [IID_W-1:0] IID_RX   = 8'h04;
    localparam logic [IID_W-1:0] IID_TX   = 8'h02;
    localparam logic [IID_W-1:0] IID_MS   = 8'h06;
    localparam logic [IID_W-1:0] IID_BRK  = 8'h00;
    localparam logic [IID_W-1:0] IID_NONE = 8'h01;

    localparam logic [IID_NSRC-1:0][IID_W-1:0] IID_CODES =
        {IID_BRK, IID_MS, IID_TX, IID_RX};

    typedef struct packed {
        logic [IID_W-1:0] iir;
        logic             irq;
    } iid_out_t;
endpackage

// File: rtl/iid_sticky_flag.sv
module iid_sticky_flag #(
    parameter bit RST_VAL = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic set_i,
    input  logic clr_i,
    output logic flag_o
);
    logic flag_d, flag_q;

    always_comb begin
        flag_d = flag_q;
        if (clr_i) flag_d = 1'b0;
        if (set_i) flag_d = 1'b1;   // set wins over clear
    end

    always_ff @(posedge clk) begin
        if (!rst_n) flag_q <= RST_VAL;
        else        flag_q <= flag_d;
    end

    assign flag_o = flag_q;

    // R10: a set in any cycle leaves the flag high afterwards
    a_r10_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
        set_i |=> flag_o);
    a_r10_clear_alone: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_i && !set_i) |=> !flag_o);
endmodule

// File: rtl/iid_prio_sel.sv
module iid_prio_sel #(
    parameter int N_SRC  = 4,
    parameter int CODE_W = 8,
    parameter logic [N_SRC-1:0][CODE_W-1:0] CODES = '0,
    parameter logic [CODE_W-1:0] IDLE_CODE = '0
) (
    input  logic [N_SRC-1:0]  req_i,
    output logic [CODE_W-1:0] code_o
);
    logic [N_SRC-1:0] grant;

    genvar g;
    generate
        for (g = 0; g < N_SRC; g++) begin : g_grant
            if (g == 0) begin : g_top
                assign grant[g] = req_i[g];
            end else begin : g_rest
                assign grant[g] = req_i[g] & ~(|req_i[g-1:0]);
            end
        end
    endgenerate

    always_comb begin
        code_o = (|req_i) ? '0 : IDLE_CODE;
        for (int i = 0; i < N_SRC; i++) begin
            if (grant[i]) code_o = code_o | CODES[i];
        end
    end
endmodule

// File: rtl/uart_irq_ident.sv
module uart_irq_ident
    import uart_iid_pkg::*;
#(
    parameter int EN_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [EN_W-1:0]  ier_en,
    input  logic             ln_data_ready,
    input  logic             ln_thr_empty,
    input  logic             ln_break,
    input  logic             modem_evt,
    input  logic             host_iir_rd,
    input  logic             host_ier_wr,
    input  logic             host_thr_wr,
    input  logic             tx_handoff,
    output logic [IID_W-1:0] iir_val,
    output logic             irq
);
    localparam int N_FLAG = 2;
    localparam int F_TX   = 0;
    localparam int F_MS   = 1;

    iid_out_t st_d, st_q;

    logic [N_FLAG-1:0] flag_set, flag_clr, flag_q;
    logic [IID_NSRC-1:0] src_req;
    logic [IID_W-1:0]    sel_code;
    logic                tx_code_read;

    // Hidden-flag side effects of host accesses
    assign tx_code_read     = host_iir_rd && (st_q.iir[2:0] == IID_TX[2:0]);
    assign flag_set[F_TX]   = (host_ier_wr && ln_thr_empty) || tx_handoff;
    assign flag_clr[F_TX]   = host_thr_wr || tx_code_read;
    assign flag_set[F_MS]   = modem_evt;
    assign flag_clr[F_MS]   = host_iir_rd;

    genvar f;
    generate
        for (f = 0; f < N_FLAG; f++) begin : g_flag
            iid_sticky_flag #(.RST_VAL(1'b0)) u_flag (
                .clk   (clk),
                .rst_n (rst_n),
                .set_i (flag_set[f]),
                .clr_i (flag_clr[f]),
                .flag_o(flag_q[f])
            );
        end
    endgenerate

    // Sources in priority order; the modem source uses enable bit 2
    assign src_req[0] = ln_data_ready && ier_en[0];
    assign src_req[1] = flag_q[F_TX]  && ier_en[1];
    assign src_req[2] = flag_q[F_MS]  && ier_en[2];
    assign src_req[3] = ln_break;

    iid_prio_sel #(
        .N_SRC    (IID_NSRC),
        .CODE_W   (IID_W),
        .CODES    (IID_CODES),
        .IDLE_CODE(IID_NONE)
    ) u_sel (
        .req_i (src_req),
        .code_o(sel_code)
    );

    always_comb begin
        st_d     = st_q;
        st_d.iir = sel_code;
        st_d.irq = (sel_code != IID_NONE);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.iir <= IID_NONE;
            st_q.irq <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign iir_val = st_q.iir;
    assign irq     = st_q.irq;

    // R2: request line agrees with the registered code
    a_r2_irq_code: assert property (@(posedge clk) disable iff (!rst_n)
        irq == (iir_val != IID_NONE));
    // R1: enabled data-ready always wins on the next edge
    a_r1_rx_top: assert property (@(posedge clk) disable iff (!rst_n)
        (ln_data_ready && ier_en[0]) |=> (iir_val == IID_RX));
    // R4: reading the transmit code without a set leaves it cleared
    a_r4_tx_read_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (host_iir_rd && iir_val == IID_TX && !host_ier_wr && !tx_handoff)
        |=> !flag_q[F_TX]);
    // R5: any read without a modem event clears the modem flag
    a_r5_ms_read_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (host_iir_rd && !modem_evt) |=> !flag_q[F_MS]);
    // R8: a modem update raises the flag
    a_r8_ms_set: assert property (@(posedge clk) disable iff (!rst_n)
        modem_evt |=> flag_q[F_MS]);
endmodule

// File: tb/sim_uart_irq_ident.sv
module sim_uart_irq_ident;
    localparam int CLK_PERIOD = 10;
    localparam int WDOG_LIMIT = 5000;
    localparam int NV = 12;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [2:0] ier_en = '0;
    logic       ln_data_ready = 1'b0, ln_thr_empty = 1'b1, ln_break = 1'b0;
    logic       modem_evt = 1'b0, host_iir_rd = 1'b0, host_ier_wr = 1'b0;
    logic       host_thr_wr = 1'b0, tx_handoff = 1'b0;
    logic [7:0] iir_val;
    logic       irq;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    uart_irq_ident u0 (
        .clk(clk), .rst_n(rst_n), .ier_en(ier_en),
        .ln_data_ready(ln_data_ready), .ln_thr_empty(ln_thr_empty),
        .ln_break(ln_break), .modem_evt(modem_evt),
        .host_iir_rd(host_iir_rd), .host_ier_wr(host_ier_wr),
        .host_thr_wr(host_thr_wr), .tx_handoff(tx_handoff),
        .iir_val(iir_val), .irq(irq)
    );

    // vector: {ier[2:0], dr, thre, brk, ier_wr pulse, modem pulse, exp[7:0]}
    localparam logic [15:0] VECS [0:NV-1] = '{
        {3'd0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 8'h01},
        {3'd1, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 8'h04},
        {3'd0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 8'h01},
        {3'd2, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 8'h02},
        {3'd2, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 8'h01},
        {3'd3, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 8'h04},
        {3'd4, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 8'h06},
        {3'd0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 8'h01},
        {3'd6, 1'b0, 1'b1, 1'b0, 1'b1, 1'b1, 8'h02},
        {3'd0, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 8'h00},
        {3'd4, 1'b0, 1'b1, 1'b1, 1'b0, 1'b1, 8'h06},
        {3'd7, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 8'h04}
    };

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: iir actual %02h expected %02h", req, act, exp);
        end
        checks++;
        if (irq !== (exp != 8'h01)) begin
            errors++;
            $display("FAIL R2 (%s): irq actual %0b expected %0b", req, irq, exp != 8'h01);
        end
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        ier_en = '0; ln_data_ready = 1'b0; ln_thr_empty = 1'b1; ln_break = 1'b0;
        modem_evt = 1'b0; host_iir_rd = 1'b0; host_ier_wr = 1'b0;
        host_thr_wr = 1'b0; tx_handoff = 1'b0;
        tick(); tick();
        rst_n = 1'b1;
    endtask

    initial begin : wdog
        for (int c = 0; c < WDOG_LIMIT; c++) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin : main
        do_reset();
        check("R3 reset", iir_val, 8'h01);

        // Table: priority (R1), enables, R6, R8
        for (int v = 0; v < NV; v++) begin
            do_reset();
            ier_en        = VECS[v][15:13];
            ln_data_ready = VECS[v][12];
            ln_thr_empty  = VECS[v][11];
            ln_break      = VECS[v][10];
            host_ier_wr   = VECS[v][9];
            modem_evt     = VECS[v][8];
            tick();
            host_ier_wr = 1'b0; modem_evt = 1'b0;
            tick();
            check($sformatf("R1/R6/R8 vector %0d", v), iir_val, VECS[v][7:0]);
        end

        // R9 + R4: read data is pre-side-effect; code stale one cycle
        do_reset();
        ier_en = 3'd2; host_ier_wr = 1'b1; tick(); host_ier_wr = 1'b0;
        check("R9 flag visible one edge later", iir_val, 8'h01);
        tick();
        check("R6 tx pending", iir_val, 8'h02);
        host_iir_rd = 1'b1; #1;
        check("R9 read data before side effect", iir_val, 8'h02);
        tick(); host_iir_rd = 1'b0;
        check("R9 code one cycle stale after read", iir_val, 8'h02);
        tick();
        check("R4 read of tx code clears", iir_val, 8'h01);

        // R4: read returning rx code leaves tx pending
        do_reset();
        ier_en = 3'd3; ln_data_ready = 1'b1; host_ier_wr = 1'b1; tick();
        host_ier_wr = 1'b0; tick();
        check("R1 rx over tx", iir_val, 8'h04);
        host_iir_rd = 1'b1; tick(); host_iir_rd = 1'b0;
        ln_data_ready = 1'b0; tick();
        check("R4 other-code read keeps tx", iir_val, 8'h02);

        // R5: read clears modem flag
        do_reset();
        ier_en = 3'd4; modem_evt = 1'b1; tick(); modem_evt = 1'b0; tick();
        check("R8 modem set", iir_val, 8'h06);
        host_iir_rd = 1'b1; tick(); host_iir_rd = 1'b0; tick();
        check("R5 read clears modem", iir_val, 8'h01);

        // R7: thr write clears, hand-off sets
        do_reset();
        ier_en = 3'd2; host_ier_wr = 1'b1; tick(); host_ier_wr = 1'b0; tick();
        host_thr_wr = 1'b1; tick(); host_thr_wr = 1'b0; tick();
        check("R7 thr write clears", iir_val, 8'h01);
        tx_handoff = 1'b1; tick(); tx_handoff = 1'b0; tick();
        check("R7 handoff sets", iir_val, 8'h02);

        // R10: collisions, set wins
        host_thr_wr = 1'b1; tx_handoff = 1'b1; tick();
        host_thr_wr = 1'b0; tx_handoff = 1'b0; tick();
        check("R10 thr write vs handoff", iir_val, 8'h02);
        do_reset();
        ier_en = 3'd4; modem_evt = 1'b1; tick(); modem_evt = 1'b0; tick();
        host_iir_rd = 1'b1; modem_evt = 1'b1; tick();
        host_iir_rd = 1'b0; modem_evt = 1'b0; tick();
        check("R10 read vs modem event", iir_val, 8'h06);

        // R3: reset clears hidden flags (enables kept high after reset)
        do_reset();
        ier_en = 3'd6; tick(); tick();
        check("R3 flags clear after reset", iir_val, 8'h01);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule